// File: doc/BRIEF.md
# Serial Programming Command Slave

This block is the target side of a four-byte serial programming link. While the programming hold input is asserted, a host drives a serial clock and a data line into the block, and the block returns data on its serial output. The serial clock is not used as a clock. It is oversampled by the system clock, so the host must keep each serial clock phase longer than a few system clocks.

Every instruction is one frame of four bytes, most significant bit first. During bytes one to three the block sends back the byte it received in the slot before. A host can therefore see whether it is aligned: the sync byte of the enable instruction returns while the third byte goes out. Read and poll instructions put their answer in place of that echo during the fourth byte.

Program memory is written through a page buffer. Single words of the buffer are loaded low byte first, high byte second, and a page write copies the whole buffer into the page chosen by the upper address bits. The nonvolatile byte store is written one byte at a time. Each commit starts a busy window, which a poll instruction reports. Both memories are plain register arrays.

Top module: `sprog_slave`

## Requirements
- R1: A frame is 32 bits, MSB first. A bit is taken on a rising edge of `sck`. `miso` changes only after a falling edge of `sck`, or when `progHold` drops. The frame completes on its 32nd rising edge.
- R2: `miso` returns 0x00 during byte 0. During byte k (k = 1, 2, 3) it returns the byte received in slot k-1, unless R8 or R9 supplies a response for byte 3. In the enable instruction (0xAC, 0x53, x, x), 0x53 therefore returns during the third byte.
- R3: After reset, and after every drop of `progHold`, no instruction other than a correct enable (byte 0 = 0xAC and byte 1 = 0x53) has any effect. Until such an enable, byte 3 echoes byte 2. An enable with a wrong byte 1 leaves the block locked.
- R4: Deasserting `progHold` discards any partial frame. The next frame after reassertion starts at bit 0.
- R5: Opcode 0x40 stores byte 3 as the low byte of buffer word (byte 2)[4:0]. Opcode 0x48 stores byte 3 as the high byte of that word, but only if that word's low byte was loaded since the last page write. Otherwise opcode 0x48 is ignored.
- R6: Opcode 0x4C copies all 32 buffer words into flash page ({byte 1, byte 2})[7:5]. The buffer keeps its contents. All low-loaded marks are cleared, so a later 0x48 without a fresh 0x40 is ignored.
- R7: Opcode 0xC0 replaces the nonvolatile byte at ({byte 1, byte 2})[5:0] with byte 3.
- R8: Opcodes 0x20 and 0x28 return, during byte 3, the low and high byte of flash word ({byte 1, byte 2})[7:0]. Opcode 0xA0 returns the nonvolatile byte at ({byte 1, byte 2})[5:0].
- R9: An accepted 0x4C or 0xC0 raises `busy` for BUSY_CYCLES system clocks. Opcode 0xF0 returns, during byte 3, `busy` in bit 0 with bits 7:1 at zero.
- R10: While `busy` is high, 0x4C and 0xC0 are ignored. Loads and reads still act.
- R11: After reset `miso` and `busy` are 0, every flash word is 0xFFFF and every nonvolatile byte is 0xFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversamples the serial link |
| rstN | input | 1 | Active-low asynchronous reset |
| progHold | input | 1 | High while the target is held in programming mode |
| sck | input | 1 | Serial clock from the host |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |
| busy | output | 1 | High while a commit window is open |

## Verification
The checks assume `sck`, `mosi` and `progHold` change far enough apart that each `sck` phase covers more than the three-flop synchroniser delay. They also assume `mosi` is stable across every rising `sck` edge and that `progHold` only changes while `sck` is low. The bench changes all inputs on the falling edge of the system clock. It holds every `sck` phase for eight system clocks and sets `mosi` a full phase before each rise. It only changes `progHold` between frames or while `sck` is low.

// File: rtl/sprog_pkg.sv
package sprog_pkg;

  localparam logic [7:0] OP_ENABLE  = 8'hAC;
  localparam logic [7:0] SYNC_BYTE  = 8'h53;
  localparam logic [7:0] OP_LOAD_LO = 8'h40;
  localparam logic [7:0] OP_LOAD_HI = 8'h48;
  localparam logic [7:0] OP_PAGE_WR = 8'h4C;
  localparam logic [7:0] OP_READ_LO = 8'h20;
  localparam logic [7:0] OP_READ_HI = 8'h28;
  localparam logic [7:0] OP_EE_WR   = 8'hC0;
  localparam logic [7:0] OP_EE_RD   = 8'hA0;
  localparam logic [7:0] OP_POLL    = 8'hF0;

  typedef struct packed {
    logic loadLo;
    logic loadHi;
    logic pageWrite;
    logic eeWrite;
  } sprogStrb_t;

  typedef enum logic [2:0] {
    RSP_ECHO,
    RSP_FLASH_LO,
    RSP_FLASH_HI,
    RSP_EE,
    RSP_BUSY
  } rspSel_t;

endpackage

// File: rtl/sprog_frame.sv
module sprog_frame (
  input  logic       clk,
  input  logic       rstN,
  input  logic       progHold,
  input  logic       sck,
  input  logic       mosi,
  input  logic [7:0] rspByte,
  output logic       active,
  output logic       frameValid,
  output logic [7:0] b0,
  output logic [7:0] b1,
  output logic [7:0] b2,
  output logic [7:0] b3,
  output logic       miso
);

  localparam int BYTES = 4;
  localparam int IDX_W = $clog2(BYTES);

  logic [2:0] sckSync;
  logic [1:0] mosiSync;
  logic [1:0] holdSync;
  logic       riseDet, fallDet, mosiBit;
  logic [2:0] bitCnt;
  logic [IDX_W-1:0] byteIdx;
  logic [6:0] rxShift;
  logic [6:0] txShift;
  logic [7:0] rxByte, nextTx;
  logic       misoR;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckSync  <= '0;
      mosiSync <= '0;
      holdSync <= '0;
    end else begin
      sckSync  <= {sckSync[1:0], sck};
      mosiSync <= {mosiSync[0], mosi};
      holdSync <= {holdSync[0], progHold};
    end
  end

  assign active  = holdSync[1];
  assign riseDet = active & sckSync[1] & ~sckSync[2];
  assign fallDet = active & ~sckSync[1] & sckSync[2];
  assign mosiBit = mosiSync[1];
  assign rxByte  = {rxShift, mosiBit};

  always_comb begin
    case (byteIdx)
      2'd1:    nextTx = b0;
      2'd2:    nextTx = b1;
      2'd3:    nextTx = rspByte;
      default: nextTx = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt     <= '0;
      byteIdx    <= '0;
      rxShift    <= '0;
      txShift    <= '0;
      misoR      <= 1'b0;
      frameValid <= 1'b0;
      b0 <= '0; b1 <= '0; b2 <= '0; b3 <= '0;
    end else begin
      frameValid <= 1'b0;
      if (!active) begin
        bitCnt  <= '0;
        byteIdx <= '0;
        misoR   <= 1'b0;
      end else begin
        if (riseDet) begin
          rxShift <= rxByte[6:0];
          bitCnt  <= bitCnt + 3'd1;
          if (bitCnt == 3'd7) begin
            case (byteIdx)
              2'd0: b0 <= rxByte;
              2'd1: b1 <= rxByte;
              2'd2: b2 <= rxByte;
              default: begin
                b3         <= rxByte;
                frameValid <= 1'b1;
              end
            endcase
            byteIdx <= byteIdx + 2'd1;
          end
        end
        if (fallDet) begin
          if (bitCnt == 3'd0) begin
            misoR   <= nextTx[7];
            txShift <= nextTx[6:0];
          end else begin
            misoR   <= txShift[6];
            txShift <= {txShift[5:0], 1'b0};
          end
        end
      end
    end
  end

  assign miso = misoR;

  // R1: the output bit moves only after a detected falling edge or a hold drop
  a_r1_miso_on_fall: assert property (@(posedge clk) disable iff (!rstN)
    (misoR != $past(misoR)) |-> ($past(fallDet) || !$past(active)));

  // R1: a frame completes only on the last rising edge of the fourth byte
  a_r1_frame_end: assert property (@(posedge clk) disable iff (!rstN)
    frameValid |-> $past(riseDet && byteIdx == 2'd3 && bitCnt == 3'd7));

endmodule

// File: rtl/sprog_ctrl.sv
module sprog_ctrl
  import sprog_pkg::*;
#(
  parameter int BUSY_CYCLES = 1500
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       active,
  input  logic       frameValid,
  input  logic [7:0] b0,
  input  logic [7:0] b1,
  output sprogStrb_t strb,
  output rspSel_t    rspSel,
  output logic       busy
);

  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

  logic             enabled;
  logic             accept;
  logic [CNT_W-1:0] busyCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                               enabled <= 1'b0;
    else if (!active)                                        enabled <= 1'b0;
    else if (frameValid && b0 == OP_ENABLE && b1 == SYNC_BYTE) enabled <= 1'b1;
  end

  assign accept = frameValid & enabled;

  always_comb begin
    strb           = '0;
    strb.loadLo    = accept && b0 == OP_LOAD_LO;
    strb.loadHi    = accept && b0 == OP_LOAD_HI;
    strb.pageWrite = accept && b0 == OP_PAGE_WR && !busy;
    strb.eeWrite   = accept && b0 == OP_EE_WR && !busy;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                               busyCnt <= '0;
    else if (strb.pageWrite || strb.eeWrite) busyCnt <= CNT_W'(BUSY_CYCLES);
    else if (busyCnt != '0)                  busyCnt <= busyCnt - 1'b1;
  end

  assign busy = busyCnt != '0;

  always_comb begin
    rspSel = RSP_ECHO;
    if (enabled) begin
      case (b0)
        OP_READ_LO: rspSel = RSP_FLASH_LO;
        OP_READ_HI: rspSel = RSP_FLASH_HI;
        OP_EE_RD:   rspSel = RSP_EE;
        OP_POLL:    rspSel = RSP_BUSY;
        default:    rspSel = RSP_ECHO;
      endcase
    end
  end

  // R3: nothing reaches the datapath before a correct enable
  a_r3_locked: assert property (@(posedge clk) disable iff (!rstN)
    !enabled |-> (strb == '0 && rspSel == RSP_ECHO));

  // R10: no commit is issued inside a busy window
  a_r10_busy_block: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !(strb.pageWrite || strb.eeWrite));

  // R9: a busy window opens only from a commit
  a_r9_busy_start: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(strb.pageWrite || strb.eeWrite));

endmodule

// File: rtl/sprog_datapath.sv
module sprog_datapath
  import sprog_pkg::*;
#(
  parameter int PAGE_BITS  = 5,
  parameter int PAGE_SEL_W = 3,
  parameter int EE_BITS    = 6
) (
  input  logic       clk,
  input  logic       rstN,
  input  sprogStrb_t strb,
  input  rspSel_t    rspSel,
  input  logic       busy,
  input  logic [7:0] b1,
  input  logic [7:0] b2,
  input  logic [7:0] b3,
  output logic [7:0] rspByte
);

  localparam int PAGE_WORDS = 1 << PAGE_BITS;
  localparam int PAGES      = 1 << PAGE_SEL_W;
  localparam int FA_BITS    = PAGE_BITS + PAGE_SEL_W;
  localparam int EE_BYTES   = 1 << EE_BITS;
  localparam int USED_BITS  = (FA_BITS > EE_BITS) ? FA_BITS : EE_BITS;

  logic [15:0]           addr;
  logic [PAGE_BITS-1:0]  offset;
  logic [PAGE_SEL_W-1:0] pageSel;
  logic [EE_BITS-1:0]    eeAddr;
  logic                  unusedAddr;

  logic [15:0] pageBuf [PAGE_WORDS];
  logic        loFlag  [PAGE_WORDS];
  logic [15:0] flashMem [PAGES][PAGE_WORDS];
  logic [7:0]  eeMem   [EE_BYTES];
  logic [15:0] flashRd;

  assign addr       = {b1, b2};
  assign offset     = addr[PAGE_BITS-1:0];
  assign pageSel    = addr[PAGE_BITS +: PAGE_SEL_W];
  assign eeAddr     = addr[EE_BITS-1:0];
  assign unusedAddr = ^addr[15:USED_BITS];

  for (genvar w = 0; w < PAGE_WORDS; w++) begin : g_word
    logic hit;
    assign hit = offset == PAGE_BITS'(w);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        pageBuf[w] <= 16'hFFFF;
        loFlag[w]  <= 1'b0;
      end else if (strb.pageWrite) begin
        loFlag[w] <= 1'b0;
      end else if (strb.loadLo && hit) begin
        pageBuf[w][7:0] <= b3;
        loFlag[w]       <= 1'b1;
      end else if (strb.loadHi && hit && loFlag[w]) begin
        pageBuf[w][15:8] <= b3;
      end
    end

    // R5: a high byte without its low byte leaves the word untouched
    a_r5_hi_needs_lo: assert property (@(posedge clk) disable iff (!rstN)
      (strb.loadHi && hit && !loFlag[w]) |=> $stable(pageBuf[w]));

    // R6: a page write clears the low-loaded mark
    a_r6_flag_clear: assert property (@(posedge clk) disable iff (!rstN)
      strb.pageWrite |=> !loFlag[w]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int p = 0; p < PAGES; p++)
        for (int w = 0; w < PAGE_WORDS; w++)
          flashMem[p][w] <= 16'hFFFF;
    end else if (strb.pageWrite) begin
      for (int w = 0; w < PAGE_WORDS; w++)
        flashMem[pageSel][w] <= pageBuf[w];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int e = 0; e < EE_BYTES; e++) eeMem[e] <= 8'hFF;
    end else if (strb.eeWrite) begin
      eeMem[eeAddr] <= b3;
    end
  end

  assign flashRd = flashMem[pageSel][offset];

  always_comb begin
    case (rspSel)
      RSP_FLASH_LO: rspByte = flashRd[7:0];
      RSP_FLASH_HI: rspByte = flashRd[15:8];
      RSP_EE:       rspByte = eeMem[eeAddr];
      RSP_BUSY:     rspByte = {7'd0, busy};
      default:      rspByte = b2;
    endcase
  end

  // R7: a byte store lands exactly the supplied value
  a_r7_ee_store: assert property (@(posedge clk) disable iff (!rstN)
    strb.eeWrite |=> eeMem[$past(eeAddr)] == $past(b3));

endmodule

// File: rtl/sprog_slave.sv
module sprog_slave
  import sprog_pkg::*;
#(
  parameter int PAGE_BITS   = 5,
  parameter int PAGE_SEL_W  = 3,
  parameter int EE_BITS     = 6,
  parameter int BUSY_CYCLES = 1500
) (
  input  logic clk,
  input  logic rstN,
  input  logic progHold,
  input  logic sck,
  input  logic mosi,
  output logic miso,
  output logic busy
);

  logic       active, frameValid;
  logic [7:0] b0, b1, b2, b3, rspByte;
  sprogStrb_t strb;
  rspSel_t    rspSel;

  sprog_frame u_frame (
    .clk, .rstN, .progHold, .sck, .mosi, .rspByte,
    .active, .frameValid, .b0, .b1, .b2, .b3, .miso
  );

  sprog_ctrl #(.BUSY_CYCLES(BUSY_CYCLES)) u_ctrl (
    .clk, .rstN, .active, .frameValid, .b0, .b1,
    .strb, .rspSel, .busy
  );

  sprog_datapath #(
    .PAGE_BITS(PAGE_BITS), .PAGE_SEL_W(PAGE_SEL_W), .EE_BITS(EE_BITS)
  ) u_dp (
    .clk, .rstN, .strb, .rspSel, .busy, .b1, .b2, .b3, .rspByte
  );

endmodule

// File: tb/sprog_slave_bench.sv
module sprog_slave_bench;

  localparam int PH   = 8;
  localparam int BUSY = 1500;
  localparam int NV   = 28;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic progHold = 1'b0;
  logic sck = 1'b0;
  logic mosi = 1'b0;
  logic miso, busy;
  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  sprog_slave #(.BUSY_CYCLES(BUSY)) u_sprog_slave (
    .clk, .rstN, .progHold, .sck, .mosi, .miso, .busy
  );

  // {req, command frame, expected miso frame, idle clocks after}
  localparam logic [87:0] VEC [NV] = '{
    {8'd3,  32'h20000300, 32'h00200003, 16'd0},    // R3 read before enable echoes
    {8'd3,  32'hAC120000, 32'h00AC1200, 16'd0},    // R3 bad sync byte
    {8'd3,  32'hC0000577, 32'h00C00005, 16'd0},    // R3 write while locked
    {8'd3,  32'hA0000500, 32'h00A00005, 16'd0},    // R3 read while locked
    {8'd2,  32'hAC530000, 32'h00AC5300, 16'd0},    // R2 0x53 echo in third byte
    {8'd11, 32'hA0000500, 32'h00A000FF, 16'd0},    // R11 erased byte, R3 write was dropped
    {8'd5,  32'h40000334, 32'h00400003, 16'd0},    // R5 low byte
    {8'd5,  32'h48000312, 32'h00480003, 16'd0},    // R5 high byte after low
    {8'd5,  32'h480004AB, 32'h00480004, 16'd0},    // R5 high byte first (ignored)
    {8'd5,  32'h400004CD, 32'h00400004, 16'd0},    // R5 low byte word 4
    {8'd6,  32'h4C002000, 32'h004C0020, 16'd0},    // R6 commit page 1
    {8'd9,  32'hF0000000, 32'h00F00001, 16'd0},    // R9 poll while busy
    {8'd10, 32'hC0000577, 32'h00C00005, 16'd2000}, // R10 store while busy
    {8'd9,  32'hF0000000, 32'h00F00000, 16'd0},    // R9 poll idle
    {8'd8,  32'h20002300, 32'h00200034, 16'd0},    // R8 flash low
    {8'd8,  32'h28002300, 32'h00280012, 16'd0},    // R8 flash high
    {8'd5,  32'h28002400, 32'h002800FF, 16'd0},    // R5 ignored high byte stays FF
    {8'd5,  32'h20002400, 32'h002000CD, 16'd0},    // R5 low byte committed
    {8'd6,  32'h20000300, 32'h002000FF, 16'd0},    // R6 other page untouched
    {8'd10, 32'hA0000500, 32'h00A000FF, 16'd0},    // R10 busy store was dropped
    {8'd7,  32'hC0000577, 32'h00C00005, 16'd2000}, // R7 store
    {8'd7,  32'hA0000500, 32'h00A00077, 16'd0},    // R7 readback
    {8'd7,  32'hC0000588, 32'h00C00005, 16'd2000}, // R7 overwrite
    {8'd7,  32'hA0000500, 32'h00A00088, 16'd0},    // R7 replaced value
    {8'd6,  32'h48000399, 32'h00480003, 16'd0},    // R6 marks cleared, high ignored
    {8'd6,  32'h4C000000, 32'h004C0000, 16'd2000}, // R6 commit page 0 from kept buffer
    {8'd6,  32'h28000300, 32'h00280012, 16'd0},    // R6 kept high byte
    {8'd1,  32'h20000300, 32'h00200034, 16'd0}     // R1 bit order and framing
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic sendBits(input logic [31:0] tx, input int n, output logic [31:0] rx);
    rx = '0;
    for (int i = 31; i > 31 - n; i--) begin
      @(negedge clk); mosi = tx[i]; sck = 1'b0;
      repeat (PH) @(negedge clk);
      rx[i] = miso;
      sck = 1'b1;
      repeat (PH) @(negedge clk);
    end
    sck = 1'b0;
    repeat (PH) @(negedge clk);
  endtask

  logic [31:0] rx;

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    progHold = 1'b1;
    repeat (10) @(negedge clk);
    check("R11 reset outputs", {30'd0, miso, busy}, 32'd0);

    for (int v = 0; v < NV; v++) begin
      sendBits(VEC[v][79:48], 32, rx);
      check($sformatf("R%0d vector %0d", VEC[v][87:80], v), rx, VEC[v][47:16]);
      repeat (int'(VEC[v][15:0])) @(negedge clk);
    end

    // R9: busy window length seen at the port
    sendBits(32'hC0000655, 32, rx);
    check("R9 busy at commit", {31'd0, busy}, 32'd1);
    repeat (BUSY - 40) @(negedge clk);
    check("R9 busy near end", {31'd0, busy}, 32'd1);
    repeat (60) @(negedge clk);
    check("R9 busy released", {31'd0, busy}, 32'd0);

    // R4: partial frame then hold drop, next frame aligned and locked again
    sendBits(32'hA0000500, 12, rx);
    progHold = 1'b0;
    repeat (10) @(negedge clk);
    check("R4 miso low out of mode", {31'd0, miso}, 32'd0);
    progHold = 1'b1;
    repeat (10) @(negedge clk);
    sendBits(32'hA0000500, 32, rx);
    check("R4 aligned and relocked", rx, 32'h00A00005);
    sendBits(32'hAC530000, 32, rx);
    sendBits(32'hA0000600, 32, rx);
    check("R4 reenabled read", rx, 32'h00A00055);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule